// File: doc/BRIEF.md
# SPI Page-Erasable Flash Device Responder

This block is the device side of a serial flash with page-level erase. It watches chip select, serial clock and serial data in from the bus, then drives serial data out. Its core clock is much faster than the serial clock, so all three bus inputs are brought in through synchronizers and their edges are found in the core clock domain. A one-byte opcode selects the command. Commands that touch the storage also take a 24-bit address, and the fast read takes an extra dummy byte after it. A status byte reports a write-in-progress flag and a write-enable latch.

The storage is a parameterized byte array organised in 256-byte pages. Three kinds of write exist: byte-exact page write (erase plus program), AND-only page program, and erase by page or by sector. Each one runs as an internal operation that starts when chip select rises. During this time a walker updates the array, and a further tail of cycles keeps the device busy. Until the operation ends, every command except the status read is dropped. A deep power-down state ignores every command except the wake-up command.

Top module: `spif_responder`

## Requirements
- R1: After reset the status byte is 00h, `miso_en` is low and every storage byte reads FFh.
- R2: Input bits are taken on rising serial clock edges and output bits change on falling edges, most significant bit first. `miso_en` is high only while a data-out phase is shifting and goes low when chip select rises.
- R3: Opcode 9Fh returns `MAKER_ID`, then 40h, then 12h, and 00h for every byte after that.
- R4: Opcode 05h streams the status byte for as long as the clock runs. Bit 0 is write-in-progress, bit 1 is the write-enable latch and the other bits are 0. This command is accepted even while an internal operation is running.
- R5: Opcode 03h takes a 3-byte address, most significant byte first, and returns bytes from consecutive addresses, running across page boundaries. Opcode 0Bh does the same after one extra dummy byte.
- R6: Opcode 06h sets the latch and 04h clears it. Opcodes 0Ah, 02h, DBh and D8h are dropped whole when the latch is clear.
- R7: Page program (02h) ANDs each data byte into storage, so bits only go from 1 to 0. Data bytes fill the page from the start column and wrap inside the same 256-byte page. Bytes that were not sent keep their value.
- R8: Page write (0Ah) leaves each byte that was sent holding exactly the sent value, and leaves the rest of the page unchanged.
- R9: Page erase (DBh) sets the addressed 256-byte page to FFh. Sector erase (D8h) sets the addressed sector of 2^min(MEM_AW,16) bytes to FFh.
- R10: Write-in-progress rises when chip select ends an accepted write or erase, and stays high for the walk length plus `TAIL_CYC` core cycles. While it is high, every opcode other than 05h is dropped. When it falls, the latch is cleared in the same cycle.
- R11: In deep power-down (entered with B9h) every opcode except ABh is dropped, and ABh leaves the state. B9h sent during an internal operation is dropped.
- R12: Commands with an effect at completion (06h, 04h, B9h, ABh, writes and erases) act only when chip select rises on a byte boundary after the whole command. A rise in the middle of a byte discards the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock (idle low or high) |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out of the device |
| miso_en | output | 1 | High while `miso` carries valid output data |

## Verification
The status read and the end of an internal operation can land in the same core cycle: write-in-progress and the latch drop together while a status byte is being loaded for output. The bench provokes this by polling status in one long chip-select window across the end of each program and erase. Every byte it collects must be either 03h or 00h; a 01h or 02h would show the two bits clearing in different cycles. A second overlap, a new command arriving while the walker is still writing, is provoked by sending reads, programs and power-down right after an erase starts, then confirming from the storage contents that none of them acted.

// File: rtl/spif_pkg.sv
`timescale 1ns/1ps
package spif_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDID  = 8'h9F;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] OP_PW    = 8'h0A;
    localparam logic [7:0] OP_PP    = 8'h02;
    localparam logic [7:0] OP_PE    = 8'hDB;
    localparam logic [7:0] OP_SE    = 8'hD8;
    localparam logic [7:0] OP_DPD   = 8'hB9;
    localparam logic [7:0] OP_RDP   = 8'hAB;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_DUMMY, PH_DIN, PH_OUT, PH_DONE, PH_DROP
    } phase_e;

    typedef enum logic [1:0] {OK_PW, OK_PP, OK_PE, OK_SE} opkind_e;
endpackage

// File: rtl/spif_sync.sv
`timescale 1ns/1ps
module spif_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/spif_store.sv
`timescale 1ns/1ps
module spif_store #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/spif_pagebuf.sv
`timescale 1ns/1ps
module spif_pagebuf #(
    parameter int PAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           we,
    input  logic [PAW-1:0] wr_idx,
    input  logic [7:0]     wr_data,
    input  logic [PAW-1:0] rd_idx,
    output logic [7:0]     rd_data,
    output logic           rd_vld
);
    localparam int LEN = 1 << PAW;

    logic [7:0]     dat_q [LEN];
    logic [LEN-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) dat_q[wr_idx] <= wr_data;
    end

    assign rd_data = dat_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
endmodule

// File: rtl/spif_responder.sv
`timescale 1ns/1ps
module spif_responder
    import spif_pkg::*;
#(
    parameter int         MEM_AW   = 10,
    parameter int         TAIL_CYC = 64,
    parameter logic [7:0] MAKER_ID = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    output logic miso_en
);
    localparam int PAGE_AW  = 8;
    localparam int PAGE_LEN = 1 << PAGE_AW;
    localparam int SECT_AW  = (MEM_AW < 16) ? MEM_AW : 16;
    localparam int SECT_LEN = 1 << SECT_AW;
    localparam int PAGE_TOT = PAGE_LEN + TAIL_CYC;
    localparam int SECT_TOT = SECT_LEN + TAIL_CYC;
    localparam int CNT_W    = $clog2(SECT_TOT + 1);
    localparam logic [MEM_AW-1:0] SECT_MASK = ~MEM_AW'(SECT_LEN - 1);

    typedef struct packed {
        phase_e              phase;
        logic [7:0]          opc;
        logic [7:0]          rx;
        logic [2:0]          bcnt;
        logic [1:0]          acnt;
        logic [MEM_AW-1:0]   addr;
        logic [7:0]          col;
        logic [7:0]          tx;
        logic [2:0]          ocnt;
        logic                load;
        logic [1:0]          idx;
        logic                miso;
        logic                miso_en;
        logic                wel;
        logic                dpd;
        logic                busy;
        opkind_e             okind;
        logic [MEM_AW-1:0]   base;
        logic [CNT_W-1:0]    cnt;
        logic                sck_p;
        logic                cs_p;
    } ctl_t;

    ctl_t st_q, st_d;

    logic [2:0]        sync_lvl;
    logic              cs_s, sck_s, mosi_s;
    logic [7:0]        rxb;
    logic              sck_r, sck_f, cs_r;
    logic [7:0]        status;
    int                wlen, wtot;
    logic [MEM_AW-1:0] walk_addr, rd_addr;
    logic [7:0]        rd_data;
    logic              mem_we;
    logic [7:0]        mem_wd;
    logic              pb_clr, pb_we, pb_vld;
    logic [7:0]        pb_widx, pb_wdat, pb_rdat;

    spif_sync #(.W(3), .RST(3'b001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mosi, sclk, cs_n}),
        .dout (sync_lvl)
    );
    assign cs_s   = sync_lvl[0];
    assign sck_s  = sync_lvl[1];
    assign mosi_s = sync_lvl[2];

    assign walk_addr = st_q.base + MEM_AW'(st_q.cnt);
    assign rd_addr   = st_q.busy ? walk_addr : st_q.addr;

    spif_store #(.AW(MEM_AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .we     (mem_we),
        .wr_addr(walk_addr),
        .wr_data(mem_wd)
    );

    spif_pagebuf #(.PAW(PAGE_AW)) u_pbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pb_clr),
        .we     (pb_we),
        .wr_idx (pb_widx),
        .wr_data(pb_wdat),
        .rd_idx (st_q.cnt[PAGE_AW-1:0]),
        .rd_data(pb_rdat),
        .rd_vld (pb_vld)
    );

    always_comb begin
        st_d    = st_q;
        rxb     = {st_q.rx[6:0], mosi_s};
        sck_r   = sck_s & ~st_q.sck_p;
        sck_f   = ~sck_s & st_q.sck_p;
        cs_r    = cs_s & ~st_q.cs_p;
        status  = {6'b0, st_q.wel, st_q.busy};
        pb_clr  = 1'b0;
        pb_we   = 1'b0;
        pb_widx = st_q.col;
        pb_wdat = rxb;
        mem_we  = 1'b0;
        mem_wd  = 8'hFF;
        wlen    = (st_q.okind == OK_SE) ? SECT_LEN : PAGE_LEN;
        wtot    = (st_q.okind == OK_SE) ? SECT_TOT : PAGE_TOT;

        st_d.sck_p = sck_s;
        st_d.cs_p  = cs_s;

        // internal operation: walk the range, then hold busy for the tail
        if (st_q.busy) begin
            if (int'(st_q.cnt) < wlen) begin
                case (st_q.okind)
                    OK_PE, OK_SE: mem_we = 1'b1;
                    OK_PW: begin
                        mem_we = pb_vld;
                        mem_wd = pb_rdat;
                    end
                    default: begin
                        mem_we = pb_vld;
                        mem_wd = rd_data & pb_rdat;
                    end
                endcase
            end
            if (int'(st_q.cnt) == wtot - 1) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // fetch the next output byte one cycle after it is requested
        if (st_q.load) begin
            st_d.load = 1'b0;
            case (st_q.opc)
                OP_RDSR: st_d.tx = status;
                OP_RDID: begin
                    case (st_q.idx)
                        2'd0:    st_d.tx = MAKER_ID;
                        2'd1:    st_d.tx = 8'h40;
                        2'd2:    st_d.tx = 8'h12;
                        default: st_d.tx = 8'h00;
                    endcase
                    if (st_q.idx != 2'd3) st_d.idx = st_q.idx + 2'd1;
                end
                default: begin
                    st_d.tx   = rd_data;
                    st_d.addr = st_q.addr + 1'b1;
                end
            endcase
        end

        if (cs_s) begin
            if (cs_r && st_q.bcnt == 3'd0) begin
                case (st_q.phase)
                    PH_DONE: begin
                        case (st_q.opc)
                            OP_WREN: st_d.wel = 1'b1;
                            OP_WRDI: st_d.wel = 1'b0;
                            OP_DPD:  st_d.dpd = 1'b1;
                            OP_RDP:  st_d.dpd = 1'b0;
                            OP_PE: begin
                                st_d.busy  = 1'b1;
                                st_d.cnt   = '0;
                                st_d.okind = OK_PE;
                                st_d.base  = {st_q.addr[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
                            end
                            OP_SE: begin
                                st_d.busy  = 1'b1;
                                st_d.cnt   = '0;
                                st_d.okind = OK_SE;
                                st_d.base  = st_q.addr & SECT_MASK;
                            end
                            default: ;
                        endcase
                    end
                    PH_DIN: begin
                        st_d.busy  = 1'b1;
                        st_d.cnt   = '0;
                        st_d.okind = (st_q.opc == OP_PW) ? OK_PW : OK_PP;
                        st_d.base  = {st_q.addr[MEM_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
                    end
                    default: ;
                endcase
            end
            st_d.phase   = PH_IDLE;
            st_d.bcnt    = 3'd0;
            st_d.acnt    = 2'd0;
            st_d.load    = 1'b0;
            st_d.miso    = 1'b0;
            st_d.miso_en = 1'b0;
        end else begin
            if (sck_f && st_q.phase == PH_OUT) begin
                st_d.miso    = st_q.tx[7];
                st_d.miso_en = 1'b1;
                st_d.tx      = {st_q.tx[6:0], 1'b0};
                st_d.ocnt    = st_q.ocnt + 3'd1;
                if (st_q.ocnt == 3'd7) st_d.load = 1'b1;
            end
            if (sck_r) begin
                st_d.rx   = rxb;
                st_d.bcnt = st_q.bcnt + 3'd1;
                if (st_q.bcnt == 3'd7) begin
                    case (st_q.phase)
                        PH_IDLE: begin
                            st_d.opc  = rxb;
                            st_d.acnt = 2'd0;
                            st_d.ocnt = 3'd0;
                            st_d.idx  = 2'd0;
                            if (st_q.dpd) begin
                                st_d.phase = (rxb == OP_RDP) ? PH_DONE : PH_DROP;
                            end else if (st_q.busy) begin
                                if (rxb == OP_RDSR) begin
                                    st_d.phase = PH_OUT;
                                    st_d.load  = 1'b1;
                                end else begin
                                    st_d.phase = PH_DROP;
                                end
                            end else begin
                                case (rxb)
                                    OP_WREN, OP_WRDI, OP_DPD, OP_RDP:
                                        st_d.phase = PH_DONE;
                                    OP_RDSR, OP_RDID: begin
                                        st_d.phase = PH_OUT;
                                        st_d.load  = 1'b1;
                                    end
                                    OP_READ, OP_FREAD:
                                        st_d.phase = PH_ADDR;
                                    OP_PW, OP_PP: begin
                                        st_d.phase = st_q.wel ? PH_ADDR : PH_DROP;
                                        pb_clr     = st_q.wel;
                                    end
                                    OP_PE, OP_SE:
                                        st_d.phase = st_q.wel ? PH_ADDR : PH_DROP;
                                    default:
                                        st_d.phase = PH_DROP;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            st_d.addr = MEM_AW'({st_q.addr, rxb});
                            st_d.acnt = st_q.acnt + 2'd1;
                            if (st_q.acnt == 2'd2) begin
                                case (st_q.opc)
                                    OP_READ: begin
                                        st_d.phase = PH_OUT;
                                        st_d.load  = 1'b1;
                                    end
                                    OP_FREAD: st_d.phase = PH_DUMMY;
                                    OP_PW, OP_PP: begin
                                        st_d.phase = PH_DIN;
                                        st_d.col   = rxb;
                                    end
                                    default: st_d.phase = PH_DONE;
                                endcase
                            end
                        end
                        PH_DUMMY: begin
                            st_d.phase = PH_OUT;
                            st_d.load  = 1'b1;
                        end
                        PH_DIN: begin
                            pb_we    = 1'b1;
                            st_d.col = st_q.col + 8'd1;
                        end
                        PH_DONE: st_d.phase = PH_DROP;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso    = st_q.miso;
    assign miso_en = st_q.miso_en;
endmodule

// File: rtl/spif_responder_chk.sv
`timescale 1ns/1ps
module spif_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic miso_en,
    input logic wip,
    input logic wel,
    input logic dpd,
    input logic mem_we
);
    // R10
    store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip);

    // R6
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    // R10
    end_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R10
    wel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !$rose(wel));

    // R11
    dpd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dpd && wip));

    // R2
    out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_lvl) |-> !miso_en);
endmodule

bind spif_responder spif_responder_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_lvl (cs_s),
    .miso_en(miso_en),
    .wip    (st_q.busy),
    .wel    (st_q.wel),
    .dpd    (st_q.dpd),
    .mem_we (mem_we)
);

// File: tb/spif_responder_bench.sv
`timescale 1ns/1ps
module spif_responder_bench;
    localparam int H = 6;
    localparam logic [7:0] MAKER = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_en;

    int total = 0;
    int bad = 0;
    bit seen_en = 1'b0;
    bit done = 1'b0;

    logic [7:0] exp_v[$];
    int         exp_r[$];
    logic [7:0] got_q[$];
    logic [7:0] wdat[$];

    always #2.5 clk = ~clk;

    spif_responder #(.MEM_AW(10), .TAIL_CYC(2000), .MAKER_ID(MAKER)) u_spif_responder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_en(miso_en)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_v.size() > 0) begin
                logic [7:0] g, e;
                int r;
                g = got_q.pop_front();
                e = exp_v.pop_front();
                r = exp_r.pop_front();
                chk(g == e, $sformatf("R%0d", r), g, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 8'h00, 8'h00);
            summary();
        end
    end

    task automatic expect_b(input logic [7:0] v, input int r);
        exp_v.push_back(v);
        exp_r.push_back(r);
    endtask

    task automatic xb(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            repeat (H) @(negedge clk);
            r[i] = miso;
            if (miso_en) seen_en = 1'b1;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_lo();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); xb(op, r); cs_hi();
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
    endtask

    task automatic opa(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        cs_lo(); xb(op, r); send_addr(a); cs_hi();
    endtask

    task automatic wr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        cs_lo(); xb(op, r); send_addr(a);
        foreach (wdat[i]) xb(wdat[i], r);
        cs_hi();
        wdat.delete();
    endtask

    task automatic rd(input logic [7:0] op, input logic [23:0] a, input int n);
        logic [7:0] r;
        cs_lo(); xb(op, r); send_addr(a);
        if (op == 8'h0B) xb(8'h00, r);
        for (int i = 0; i < n; i++) begin xb(8'h00, r); got_q.push_back(r); end
        cs_hi();
    endtask

    task automatic rout(input logic [7:0] op, input int n);
        logic [7:0] r;
        cs_lo(); xb(op, r);
        for (int i = 0; i < n; i++) begin xb(8'h00, r); got_q.push_back(r); end
        cs_hi();
    endtask

    task automatic partial(input logic [7:0] op, input int nbits);
        cs_lo();
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = op[i];
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        cs_hi();
    endtask

    // R10: poll status in one window; both bits must drop together
    task automatic poll();
        logic [7:0] r;
        bit ok = 1'b1;
        logic [7:0] bad_v = 8'h00;
        cs_lo(); xb(8'h05, r);
        for (int i = 0; i < 100; i++) begin
            xb(8'h00, r);
            if (r == 8'h00) break;
            if (r != 8'h03) begin ok = 1'b0; bad_v = r; end
        end
        cs_hi();
        chk(ok && r == 8'h00, "R10", ok ? r : bad_v, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk(miso_en == 1'b0, "R1", {7'b0, miso_en}, 8'h00);
        rout(8'h05, 1); expect_b(8'h00, 1);
        rd(8'h03, 24'h000000, 2); expect_b(8'hFF, 1); expect_b(8'hFF, 1);

        // R2 output enable seen during data, low after release
        seen_en = 1'b0;
        // R3 identification
        rout(8'h9F, 4);
        expect_b(MAKER, 3); expect_b(8'h40, 3); expect_b(8'h12, 3); expect_b(8'h00, 3);
        chk(seen_en == 1'b1, "R2", {7'b0, seen_en}, 8'h01);
        chk(miso_en == 1'b0, "R2", {7'b0, miso_en}, 8'h00);

        // R6 program without latch is dropped
        wdat.push_back(8'h00); wr(8'h02, 24'h000010);
        rd(8'h03, 24'h000010, 1); expect_b(8'hFF, 6);

        // R6 latch set / clear, R4 streaming
        op1(8'h06);
        rout(8'h05, 2); expect_b(8'h02, 4); expect_b(8'h02, 4);
        op1(8'h04);
        rout(8'h05, 1); expect_b(8'h00, 6);

        // R12 partial opcode discarded
        partial(8'h06, 5);
        rout(8'h05, 1); expect_b(8'h00, 12);

        // R7 program two bytes
        op1(8'h06);
        wdat.push_back(8'hA5); wdat.push_back(8'h3C); wr(8'h02, 24'h000010);
        rout(8'h05, 1); expect_b(8'h03, 10);
        poll();
        rout(8'h05, 1); expect_b(8'h00, 10);
        rd(8'h03, 24'h00000F, 4);
        expect_b(8'hFF, 7); expect_b(8'hA5, 7); expect_b(8'h3C, 7); expect_b(8'hFF, 7);

        // R7 program only clears bits
        op1(8'h06);
        wdat.push_back(8'h5A); wr(8'h02, 24'h000010);
        poll();
        rd(8'h03, 24'h000010, 2); expect_b(8'h00, 7); expect_b(8'h3C, 7);

        // R8 page write sets the exact value
        op1(8'h06);
        wdat.push_back(8'h5A); wr(8'h0A, 24'h000010);
        poll();
        rd(8'h03, 24'h00000F, 3); expect_b(8'hFF, 8); expect_b(8'h5A, 8); expect_b(8'h3C, 8);

        // R7 wrap inside page; R5 read runs across page boundary
        op1(8'h06);
        wdat.push_back(8'h11); wdat.push_back(8'h22); wdat.push_back(8'h33);
        wr(8'h02, 24'h0001FE);
        poll();
        rd(8'h03, 24'h0001FE, 3); expect_b(8'h11, 5); expect_b(8'h22, 5); expect_b(8'hFF, 5);
        rd(8'h03, 24'h000100, 1); expect_b(8'h33, 7);

        // R10 commands dropped while page erase runs; R4 status allowed
        op1(8'h06);
        opa(8'hDB, 24'h000150);
        rd(8'h03, 24'h000010, 2); expect_b(8'h00, 10); expect_b(8'h00, 10);
        wdat.push_back(8'h00); wr(8'h02, 24'h000020);
        op1(8'hB9);
        rout(8'h05, 1); expect_b(8'h03, 4);
        poll();
        // R9 page erased, neighbours intact
        rd(8'h03, 24'h000100, 1); expect_b(8'hFF, 9);
        rd(8'h03, 24'h0001FE, 2); expect_b(8'hFF, 9); expect_b(8'hFF, 9);
        rd(8'h03, 24'h000020, 1); expect_b(8'hFF, 10);
        // R11 power-down during busy was dropped: id still answers
        rout(8'h9F, 1); expect_b(MAKER, 11);

        // R5 fast read with dummy byte
        rd(8'h0B, 24'h000010, 2); expect_b(8'h5A, 5); expect_b(8'h3C, 5);

        // R12 erase with stray bits before release is discarded
        op1(8'h06);
        cs_lo();
        begin
            logic [7:0] r;
            xb(8'hDB, r); send_addr(24'h000000);
        end
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            repeat (H) @(negedge clk); sclk = 1'b1;
            repeat (H) @(negedge clk); sclk = 1'b0;
        end
        cs_hi();
        rout(8'h05, 1); expect_b(8'h02, 12);
        rd(8'h03, 24'h000010, 1); expect_b(8'h5A, 12);

        // R9 sector erase
        opa(8'hD8, 24'h000000);
        poll();
        rd(8'h03, 24'h000010, 2); expect_b(8'hFF, 9); expect_b(8'hFF, 9);

        // R11 deep power-down
        op1(8'h06);
        op1(8'hB9);
        rout(8'h05, 1); expect_b(8'h00, 11);
        op1(8'h04);
        rout(8'h9F, 1); expect_b(8'h00, 11);
        op1(8'hAB);
        rout(8'h05, 1); expect_b(8'h02, 11);

        repeat (20) @(negedge clk);
        chk(exp_v.size() == 0 && got_q.size() == 0, "scoreboard",
            8'(got_q.size()), 8'(exp_v.size()));
        done = 1'b1;
        summary();
    end
endmodule